// File: doc/BRIEF.md
# Video Line Clamp Pulse Generator

This block runs on the pixel clock and derives two timing pulses per video line from a raw, active-high horizontal sync input. The first is a clamp pulse that marks the black-level reference interval after sync. It starts a programmable number of pixel periods after the falling (trailing) edge of sync and lasts a programmable number of pixel periods. The second is a regenerated horizontal sync output. It starts from the rising (leading) edge of sync and its width is counted in pixel clocks.

A mode pin selects where the clamp comes from. With the pin low, the clamp is built internally from the placement and duration settings. With the pin high, an external clamp input is registered once and passed to the clamp output, and both settings are ignored.

Each pulse latches its settings at the sync edge that starts it. Settings therefore take effect from the next line start. Both pulses are made by one timer design, which has a wait phase followed by an active phase. The timer is instantiated once for each pulse. There is no data stream, so all pins are plain level signals without a handshake.

Top module: `line_clamp_gen`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released, `clamp_out` and `hsync_out` are 0.
- R2: In internal mode (`clamp_ext_mode`=0) with placement P in 1..255, `clamp_out` rises just after the (P+3)th rising clock edge that follows a falling edge of `hsync_in`. Two of those edges are synchronizer stages and one is the edge-detect stage.
- R3: In internal mode, an internal clamp with duration D in 1..255 stays high for exactly D clock cycles.
- R4: A placement of 0 behaves exactly as a placement of 1.
- R5: A duration of 0 produces no clamp pulse for that line.
- R6: In external mode (`clamp_ext_mode`=1), `clamp_out` equals `ext_clamp_in` delayed by one clock. Sync edges and the placement and duration settings have no effect on `clamp_out`.
- R7: When `hsync_in` rises, `hsync_out` goes high just after the 4th rising clock edge and stays high for exactly W cycles, where W is the `hs_width` value.
- R8: An `hs_width` of 0 yields no `hsync_out` pulse.
- R9: If a new falling sync edge is detected while a clamp is pending or active, the clamp timing restarts from that new edge.
- R10: Placement, duration and width are captured at the detecting sync edge. Changes made after that edge do not alter the pulse already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Raw horizontal sync, active high, asynchronous |
| ext_clamp_in | input | 1 | External clamp used in external mode |
| clamp_ext_mode | input | 1 | 0: internal clamp, 1: external clamp |
| clamp_place | input | 8 | Clamp start offset in pixel periods after the sync trailing edge |
| clamp_len | input | 8 | Clamp duration in pixel periods |
| hs_width | input | 8 | Regenerated sync width in pixel clocks |
| clamp_out | output | 1 | Clamp pulse |
| hsync_out | output | 1 | Regenerated horizontal sync |

## Verification
The assertions assume that `hsync_in` holds each level long enough for the synchronizer and the edge detector to see both of its edges. A sync glitch shorter than the synchronizer depth is not covered. The pass-through check assumes that the mode pin has been stable for at least one clock since reset. The stimulus holds every sync level for at least four clocks. It changes settings only at falling clock edges, and in the capture test it changes them only after the detecting edge.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE = 2'd0,
    TMR_WAIT = 2'd1,
    TMR_ACT  = 2'd2
  } tmr_state_e;

  localparam int unsigned LCG_SYNC_STAGES = 2;
endpackage

// File: rtl/lcg_edge_detect.sv
module lcg_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lead,
  output logic trail
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   synced;
  logic                   dly;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= 1'b0;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign synced = chain[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly <= 1'b0;
    else        dly <= synced;
  end

  assign lead  = synced & ~dly;
  assign trail = ~synced & dly;
endmodule

// File: rtl/lcg_pulse_timer.sv
module lcg_pulse_timer
  import lcg_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [CW-1:0] delay,
  input  logic [CW-1:0] len,
  output logic          pulse
);
  localparam logic [CW-1:0] ONE = CW'(1);

  tmr_state_e    state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TMR_IDLE;
      cnt   <= '0;
      len_q <= '0;
    end else if (trig) begin
      state <= TMR_WAIT;
      cnt   <= (delay == '0) ? ONE : delay;
      len_q <= len;
    end else begin
      case (state)
        TMR_WAIT: begin
          if (cnt == ONE) begin
            if (len_q == '0) begin
              state <= TMR_IDLE;
            end else begin
              state <= TMR_ACT;
              cnt   <= len_q;
            end
          end else begin
            cnt <= cnt - ONE;
          end
        end
        TMR_ACT: begin
          if (cnt == ONE) state <= TMR_IDLE;
          else            cnt   <= cnt - ONE;
        end
        default: state <= TMR_IDLE;
      endcase
    end
  end

  assign pulse = (state == TMR_ACT);

  // R9
  restart_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !pulse);

  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TMR_WAIT && cnt == ONE && len_q == '0 && !trig) |=> !pulse);

  // R3
  active_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (cnt != '0 && cnt <= len_q));

  // R4
  wait_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TMR_WAIT) |-> (cnt != '0));
endmodule

// File: rtl/line_clamp_gen.sv
module line_clamp_gen
  import lcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_in,
  input  logic       ext_clamp_in,
  input  logic       clamp_ext_mode,
  input  logic [7:0] clamp_place,
  input  logic [7:0] clamp_len,
  input  logic [7:0] hs_width,
  output logic       clamp_out,
  output logic       hsync_out
);
  localparam int unsigned CW = 8;
  localparam logic [CW-1:0] HS_DELAY = CW'(1);

  logic sync_lead;
  logic sync_trail;
  logic int_clamp;
  logic ext_q;
  logic past_ok;

  lcg_edge_detect #(.SYNC_STAGES(LCG_SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (hsync_in),
    .lead  (sync_lead),
    .trail (sync_trail)
  );

  lcg_pulse_timer #(.CW(CW)) u_clamp_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (sync_trail),
    .delay (clamp_place),
    .len   (clamp_len),
    .pulse (int_clamp)
  );

  lcg_pulse_timer #(.CW(CW)) u_hs_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (sync_lead),
    .delay (HS_DELAY),
    .len   (hs_width),
    .pulse (hsync_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      ext_q   <= ext_clamp_in;
      past_ok <= 1'b1;
    end
  end

  assign clamp_out = clamp_ext_mode ? ext_q : int_clamp;

  // R6
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && clamp_ext_mode) |-> (clamp_out == $past(ext_clamp_in)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !past_ok |-> (!hsync_out && !int_clamp));
endmodule

// File: tb/line_clamp_gen_tb.sv
module line_clamp_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_in = 1'b0;
  logic       ext_clamp_in = 1'b0;
  logic       clamp_ext_mode = 1'b0;
  logic [7:0] clamp_place = 8'd1;
  logic [7:0] clamp_len = 8'd1;
  logic [7:0] hs_width = 8'd1;
  logic       clamp_out;
  logic       hsync_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  line_clamp_gen u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .ext_clamp_in(ext_clamp_in),
    .clamp_ext_mode(clamp_ext_mode), .clamp_place(clamp_place), .clamp_len(clamp_len),
    .hs_width(hs_width), .clamp_out(clamp_out), .hsync_out(hsync_out)
  );

  // Samples `total` falling clock edges, starting with the one that follows the
  // stimulus. Expects the chosen output high for k in [start, start+len-1].
  task automatic observe(input bit sel_hs, input int start, input int len,
                         input int total, input string tag);
    int bad = 0;
    int first_bad = -1;
    bit act_v = 0;
    bit exp_v = 0;
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      act_v = sel_hs ? hsync_out : clamp_out;
      exp_v = (len > 0) && (k >= start) && (k < start + len);
      if (act_v !== exp_v) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL %s: %0d mismatched cycles, first at k=%0d (actual window vs expected start=%0d len=%0d)",
               tag, bad, first_bad, start, len);
    end
  endtask

  task automatic rise_settle();
    @(negedge clk);
    hsync_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    checks++;
    if (clamp_out !== 1'b0 || hsync_out !== 1'b0) begin
      failures++;
      $display("FAIL R1: in reset clamp=%b hs=%b expected 0 0", clamp_out, hsync_out);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (clamp_out !== 1'b0 || hsync_out !== 1'b0) begin
      failures++;
      $display("FAIL R1: after reset clamp=%b hs=%b expected 0 0", clamp_out, hsync_out);
    end
  endtask

  task automatic t_clamp(input int p, input int d, input string tag);
    int eff_p = (p == 0) ? 1 : p;
    rise_settle();
    @(negedge clk);
    clamp_place = 8'(p);
    clamp_len = 8'(d);
    hsync_in = 1'b0;
    observe(1'b0, 3 + eff_p, d, 3 + eff_p + d + 6, tag);
  endtask

  task automatic t_hs(input int w, input string tag);
    @(negedge clk);
    hsync_in = 1'b0;
    repeat (6) @(negedge clk);
    @(negedge clk);
    hs_width = 8'(w);
    hsync_in = 1'b1;
    observe(1'b1, 4, w, w + 10, tag);
  endtask

  task automatic t_ext();
    bit prev = 0;
    bit pat [16] = '{1,0,1,1,0,0,1,0,1,1,1,0,0,1,0,1};
    @(negedge clk);
    clamp_ext_mode = 1'b1;
    ext_clamp_in = 1'b0;
    rise_settle();
    @(negedge clk);
    clamp_place = 8'd2;
    clamp_len = 8'd5;
    hsync_in = 1'b0;
    observe(1'b0, 0, 0, 20, "R6 settings ignored");
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (i > 0) begin
        checks++;
        if (clamp_out !== prev) begin
          failures++;
          $display("FAIL R6: step %0d clamp=%b expected %b", i, clamp_out, prev);
        end
      end
      ext_clamp_in = pat[i];
      prev = pat[i];
    end
    @(negedge clk);
    ext_clamp_in = 1'b0;
    clamp_ext_mode = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_restart();
    int bad = 0;
    bit exp_v = 0;
    rise_settle();
    @(negedge clk);
    clamp_place = 8'd10;
    clamp_len = 8'd5;
    hsync_in = 1'b0;
    for (int k = 1; k <= 34; k++) begin
      @(negedge clk);
      exp_v = (k >= 21) && (k < 26);
      if (clamp_out !== exp_v) bad++;
      if (k == 4) hsync_in = 1'b1;
      if (k == 8) hsync_in = 1'b0;
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL R9: %0d mismatched cycles, actual differs from expected window [21,25]", bad);
    end
  endtask

  task automatic t_latch();
    int bad = 0;
    bit exp_v = 0;
    rise_settle();
    @(negedge clk);
    clamp_place = 8'd3;
    clamp_len = 8'd6;
    hsync_in = 1'b0;
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      exp_v = (k >= 6) && (k < 12);
      if (clamp_out !== exp_v) bad++;
      if (k == 4) begin
        clamp_place = 8'd50;
        clamp_len = 8'd1;
      end
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL R10: %0d mismatched cycles, actual differs from expected window [6,11]", bad);
    end
  endtask

  initial begin
    t_reset();
    t_clamp(1, 1, "R2 R3 p1 d1");
    t_clamp(5, 7, "R2 R3 p5 d7");
    t_clamp(40, 20, "R2 R3 p40 d20");
    t_clamp(0, 3, "R4 place zero");
    t_clamp(6, 0, "R5 len zero");
    t_hs(3, "R7 width3");
    t_hs(12, "R7 width12");
    t_hs(0, "R8 width zero");
    t_ext();
    t_restart();
    t_latch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule